// File: doc/BRIEF.md
# Multifunction 32-bit ALU

This block is a purely combinational arithmetic logic unit for a single-cycle datapath. It takes two operands, a shift distance and a seven-bit operation word, and returns one result word. It also drives two flags: one for an all-zero result and one for signed overflow. Four units work in parallel and a final selector passes one of their outputs to the result. The units are a barrel shifter, an adder/subtractor, a bitwise logic unit and a signed set-less-than path.

The operation word holds four fixed fields. Bits [6:5] choose the unit. Bit [4] chooses subtraction. Bits [3:2] choose the bitwise function. Bits [1:0] choose the shift kind. The shifter turns every shift into a right shift of a widened operand. It handles a left shift by using the ones' complement of the distance. Set-less-than reuses the subtractor and compares nothing directly.

Top module: `alu_multi`

## Requirements
- R1: opcode[6:5] chooses the result source: 00 shifter, 01 set-less-than, 10 adder/subtractor, 11 logic unit.
- R2: With opcode[6:5]=11, opcode[3:2] selects AND (00), OR (01), NOR (10) or XOR (11) of op_a and op_b.
- R3: With opcode[6:5]=10, the result is op_a+op_b when opcode[4]=0 and op_a-op_b (modulo 2^32) when opcode[4]=1.
- R4: With opcode[6:5]=01, the result is 1 when op_a is less than op_b as signed two's-complement numbers, else 0. This holds whatever the value of opcode[4] and even when the difference overflows.
- R5: With opcode[6:5]=10, overflow is 1 exactly when the signed sum or difference does not fit in 32 bits.
- R6: overflow is 0 whenever opcode[6:5] is not 10.
- R7: zero is 1 exactly when all 32 result bits are 0, for every selection.
- R8: With opcode[6:5]=00, shift code 00 shifts op_a left by shamt and code 10 shifts it right by shamt. Both fill with zeros.
- R9: Shift code 01 shifts op_a right by shamt and fills with copies of op_a[31].
- R10: Shift code 11 rotates op_a right by shamt. Distance 0 returns op_a unchanged.
- R11: Fields that belong to an unselected unit (shift code, logic code, shamt, and the subtract bit outside arithmetic and set-less-than) do not change the result or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand; also the data that is shifted |
| op_b | input | 32 | Second operand |
| shamt | input | 5 | Shift or rotate distance |
| opcode | input | 7 | {unit select[1:0], subtract, logic code[1:0], shift code[1:0]} |
| result | output | 32 | Selected unit output |
| zero | output | 1 | Result is all zeros |
| overflow | output | 1 | Signed overflow of the arithmetic unit |

## Verification
Every output is a combinational function of the present inputs, so each result and both flags are due in the same cycle as the stimulus. No register lies on any path. The bench applies each input vector on a falling clock edge and reads the outputs one nanosecond later. That leaves the ports settled long before the next rising edge. The shifter is swept over all 32 distances for all four kinds. The arithmetic, compare and logic paths are driven with every pairing of boundary operands plus a random set.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    RS_SHIFT = 2'b00,
    RS_SLT   = 2'b01,
    RS_ARITH = 2'b10,
    RS_LOGIC = 2'b11
  } res_sel_e;

  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_NOR = 2'b10,
    LG_XOR = 2'b11
  } logic_op_e;

  typedef enum logic [1:0] {
    SH_LL = 2'b00,
    SH_RA = 2'b01,
    SH_RL = 2'b10,
    SH_RR = 2'b11
  } shift_op_e;

  typedef struct packed {
    res_sel_e  sel;
    logic      sub;
    logic_op_e lop;
    shift_op_e sop;
  } alu_op_t;

endpackage

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int SAW = $clog2(W)
) (
  input  logic [W-1:0]   data,
  input  logic [SAW-1:0] amt,
  input  shift_op_e      kind,
  output logic [W-1:0]   out
);
  localparam int EW = 2 * W - 1;

  logic [EW-1:0]  ext_word;
  logic [SAW-1:0] eff_amt;
  logic [EW-1:0]  stage [0:SAW];

  // widen the operand so that every kind becomes a plain right shift
  always_comb begin
    unique case (kind)
      SH_LL:   ext_word = {data, {(W-1){1'b0}}};
      SH_RL:   ext_word = {{(W-1){1'b0}}, data};
      SH_RA:   ext_word = {{(W-1){data[W-1]}}, data};
      default: ext_word = {data[W-2:0], data};
    endcase
  end

  // a left shift by n equals a right shift by (W-1-n) of the widened word
  assign eff_amt  = (kind == SH_LL) ? ~amt : amt;
  assign stage[0] = ext_word;

  for (genvar k = 0; k < SAW; k++) begin : g_stage
    assign stage[k+1] = eff_amt[k] ? (stage[k] >> (1 << k)) : stage[k];
  end

  assign out = stage[SAW][W-1:0];

  // rotation keeps every bit, so the population count cannot change (R10)
  always_comb begin
    p_ror_popcount_r10: assert (kind != SH_RR || $countones(out) == $countones(data))
      else $error("rotate changed population count");
  end

  // arithmetic right shift keeps the sign bit (R9)
  always_comb begin
    p_sra_sign_r9: assert (kind != SH_RA || out[W-1] == data[W-1])
      else $error("arithmetic shift lost sign");
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf
);
  function automatic logic [W-1:0] add_cin(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic cin);
    return x + y + {{(W-1){1'b0}}, cin};
  endfunction

  function automatic logic signed_ovf(input logic xs, input logic ys, input logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

  logic [W-1:0] b_eff;

  assign b_eff = sub ? ~b : b;
  assign sum   = add_cin(a, b_eff, sub);
  assign ovf   = signed_ovf(a[W-1], b_eff[W-1], sum[W-1]);

  // inverted operand plus forced carry must equal true subtraction (R3)
  always_comb begin
    p_sub_matches_r3: assert (!sub || sum == a - b)
      else $error("subtract path mismatch");
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_op_e    code,
  output logic [W-1:0] out
);
  always_comb begin
    unique case (code)
      LG_AND:  out = a & b;
      LG_OR:   out = a | b;
      LG_NOR:  out = ~(a | b);
      default: out = a ^ b;
    endcase
  end

  // OR covers both inputs, AND lies inside both inputs (R2)
  always_comb begin
    p_or_covers_r2: assert (code != LG_OR || ((out & a) == a && (out & b) == b))
      else $error("OR result does not cover inputs");
    p_and_inside_r2: assert (code != LG_AND || ((out | a) == a && (out | b) == b))
      else $error("AND result outside inputs");
  end

endmodule

// File: rtl/alu_multi.sv
module alu_multi
  import alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int SAW = $clog2(W)
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic [SAW-1:0] shamt,
  input  logic [6:0]     opcode,
  output logic [W-1:0]   result,
  output logic           zero,
  output logic           overflow
);
  alu_op_t      op;
  logic [W-1:0] sh_out;
  logic [W-1:0] as_sum;
  logic         as_ovf;
  logic [W-1:0] lg_out;
  logic [W-1:0] slt_out;
  logic         sub_en;
  logic         less;

  assign op     = alu_op_t'(opcode);
  assign sub_en = op.sub | (op.sel == RS_SLT);

  alu_shifter #(.W(W), .SAW(SAW)) u_shift (
    .data (op_a),
    .amt  (shamt),
    .kind (op.sop),
    .out  (sh_out)
  );

  alu_addsub #(.W(W)) u_addsub (
    .a   (op_a),
    .b   (op_b),
    .sub (sub_en),
    .sum (as_sum),
    .ovf (as_ovf)
  );

  alu_logic #(.W(W)) u_logic (
    .a    (op_a),
    .b    (op_b),
    .code (op.lop),
    .out  (lg_out)
  );

  // signed less-than from the difference's sign corrected by overflow
  assign less    = as_sum[W-1] ^ as_ovf;
  assign slt_out = {{(W-1){1'b0}}, less};

  always_comb begin
    unique case (op.sel)
      RS_SHIFT: result = sh_out;
      RS_SLT:   result = slt_out;
      RS_ARITH: result = as_sum;
      default:  result = lg_out;
    endcase
  end

  assign zero     = ~|result;
  assign overflow = (op.sel == RS_ARITH) & as_ovf;

  always_comb begin
    p_no_overflow_r6: assert (op.sel == RS_ARITH || !overflow)
      else $error("overflow outside arithmetic");
    p_slt_binary_r4: assert (op.sel != RS_SLT || result[W-1:1] == '0)
      else $error("set-less-than not 0 or 1");
    p_zero_shift_r7: assert (!(zero && op.sel == RS_SHIFT) || sh_out == '0)
      else $error("zero flag disagrees with shifter");
    p_zero_logic_r7: assert (!(zero && op.sel == RS_LOGIC) || lg_out == '0)
      else $error("zero flag disagrees with logic unit");
  end

endmodule

// File: tb/alu_multi_tb.sv
module alu_multi_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a, op_b, result;
  logic [4:0]  shamt;
  logic [6:0]  opcode;
  logic        zero, overflow;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  alu_multi u_dut (
    .op_a(op_a), .op_b(op_b), .shamt(shamt), .opcode(opcode),
    .result(result), .zero(zero), .overflow(overflow)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_errors = n_errors + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  logic [31:0] corners [6];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: a=%h b=%h sa=%0d op=%b actual=%h expected=%h",
               tag, op_a, op_b, shamt, opcode, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [4:0] sa,
                       input logic [6:0] op);
    @(negedge clk);
    op_a = a; op_b = b; shamt = sa; opcode = op;
    #1;
  endtask

  function automatic logic [31:0] ref_shift(input logic [1:0] k, input logic [31:0] d,
                                            input logic [4:0] sa);
    case (k)
      2'b00: return d << sa;
      2'b10: return d >> sa;
      2'b01: return 32'($signed(d) >>> sa);
      default: return (sa == 0) ? d : ((d >> sa) | (d << (6'd32 - {1'b0, sa})));
    endcase
  endfunction

  function automatic logic [31:0] ref_logic(input logic [1:0] k, input logic [31:0] a,
                                            input logic [31:0] b);
    case (k)
      2'b00: return a & b;
      2'b01: return a | b;
      2'b10: return ~(a | b);
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic ref_ovf(input logic s, input logic [31:0] a, input logic [31:0] b);
    logic signed [32:0] w;
    w = s ? ($signed({a[31], a}) - $signed({b[31], b})) : ($signed({a[31], a}) + $signed({b[31], b}));
    return w[32] != w[31];
  endfunction

  task automatic run_pair(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] exp;
    for (int s = 0; s < 2; s++) begin
      exp = s ? a - b : a + b;
      drive(a, b, 5'd0, {2'b10, s[0], 4'b0000});
      chk("R3 add/sub result", result, exp);
      chk("R5 overflow", {31'd0, overflow}, {31'd0, ref_ovf(s[0], a, b)});
      chk("R7 zero flag", {31'd0, zero}, {31'd0, exp == 0});
      // R11: junk in the logic, shift and distance fields
      drive(a, b, 5'd19, {2'b10, s[0], 4'b1011});
      chk("R11 arith ignores other fields", result, exp);
      // R4 slt, subtract bit varied
      drive(a, b, 5'd7, {2'b01, s[0], 4'b0110});
      exp = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      chk("R4 set-less-than", result, exp);
      chk("R6 no overflow on slt", {31'd0, overflow}, 32'd0);
      chk("R7 zero flag slt", {31'd0, zero}, {31'd0, exp == 0});
    end
    for (int k = 0; k < 4; k++) begin
      exp = ref_logic(k[1:0], a, b);
      drive(a, b, 5'd13, {2'b11, 1'b1, k[1:0], 2'b11});
      chk("R2 logic op", result, exp);
      chk("R6 no overflow on logic", {31'd0, overflow}, 32'd0);
      chk("R7 zero flag logic", {31'd0, zero}, {31'd0, exp == 0});
    end
  endtask

  initial begin
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001; corners[2] = 32'hFFFF_FFFF;
    corners[3] = 32'h8000_0000; corners[4] = 32'h7FFF_FFFF; corners[5] = 32'hA5C3_0F96;
    op_a = '0; op_b = '0; shamt = '0; opcode = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // reset state: all-zero inputs select shift of zero
    drive(32'd0, 32'd0, 5'd0, 7'd0);
    chk("R1 idle result", result, 32'd0);
    chk("R7 idle zero", {31'd0, zero}, 32'd1);
    chk("R6 idle overflow", {31'd0, overflow}, 32'd0);

    // R1 distinct sources for the same operands
    drive(32'h0000_00F0, 32'h0000_000F, 5'd4, {2'b00, 1'b0, 2'b00, 2'b10});
    chk("R1 sel shifter", result, 32'h0000_000F);
    drive(32'h0000_00F0, 32'h0000_000F, 5'd4, {2'b10, 1'b0, 2'b00, 2'b10});
    chk("R1 sel arith", result, 32'h0000_00FF);
    drive(32'h0000_00F0, 32'h0000_000F, 5'd4, {2'b11, 1'b0, 2'b00, 2'b10});
    chk("R1 sel logic", result, 32'h0000_0000);
    drive(32'h0000_00F0, 32'h0000_000F, 5'd4, {2'b01, 1'b0, 2'b00, 2'b10});
    chk("R1 sel slt", result, 32'h0000_0000);

    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        run_pair(corners[i], corners[j]);
    for (int n = 0; n < 300; n++)
      run_pair($urandom, $urandom);

    // shifter sweep over all kinds and distances
    for (int i = 0; i < 6; i++)
      for (int k = 0; k < 4; k++)
        for (int sa = 0; sa < 32; sa++) begin
          logic [31:0] exp;
          exp = ref_shift(k[1:0], corners[i], sa[4:0]);
          drive(corners[i], $urandom, sa[4:0], {2'b00, 1'b1, 2'b01, k[1:0]});
          case (k)
            0, 2: chk("R8 logical shift", result, exp);
            1:    chk("R9 arithmetic shift", result, exp);
            default: chk("R10 rotate", result, exp);
          endcase
          chk("R6 no overflow on shift", {31'd0, overflow}, 32'd0);
          chk("R7 zero flag shift", {31'd0, zero}, {31'd0, exp == 0});
        end
    for (int n = 0; n < 400; n++) begin
      logic [31:0] d;
      logic [4:0]  sa;
      logic [1:0]  k;
      d = $urandom; sa = 5'($urandom); k = 2'($urandom);
      drive(d, $urandom, sa, {2'b00, 1'($urandom), 2'($urandom), k});
      chk("R11 shift ignores op_b and other codes", result, ref_shift(k, d, sa));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule